// File: doc/BRIEF.md
# Event Interrupt Collector

This block gathers thirteen single-cycle event pulses raised by an encoder core and turns them into one level-sensitive interrupt line for the host. Each event has its own bit in four word registers: an enable that decides whether the event is recorded, a mask that hides a recorded event from the interrupt line, a write-one-to-clear register, and the sticky state register that holds recorded events.

Software sets the enable and mask bits once, waits for the interrupt line, reads the state register to find the cause, and writes ones to the clear register to acknowledge. The register port is a plain single-cycle access: a write is taken on the clock edge when the write strobe is high, and read data follows the address combinationally.

Bit positions, shared by all four registers: 0 frame done, 1 chain node done, 2 safe-clear done, 3 slice done, 4 stream buffer overflow, 5 stream buffer section written, 6 frame error, 7 watchdog timeout, 8 chain operation error, 9 chain error stop, 10 chain forced pause, 11 chain node stop, 12 chain data error. Bits 31 to 13 are reserved.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the enable (offset 0x10), mask (0x14), clear (0x18) and state (0x1C) registers all read zero and the interrupt line is low.
- R2: The enable and mask registers read back the value last written to bits 12 to 0; bits 31 to 13 of every read, and every read of an unmapped offset, return zero.
- R3: An event pulse on a bit whose enable bit is one sets that state bit at the clock edge on which the pulse is sampled.
- R4: An event pulse on a bit whose enable bit is zero leaves the state bit at zero.
- R5: A write of a value to the clear register offset clears exactly the state bits where that value has a one; all other state bits keep their value.
- R6: When an enabled event and a clear of the same bit meet on one clock edge, the state bit ends set.
- R7: The clear register always reads back as zero.
- R8: The interrupt line is high exactly when some state bit is one while its mask bit is zero; masking a bit does not change the state register.
- R9: A state bit stays set with no further events until it is cleared, and clearing its enable bit does not clear it.
- R10: A write to the state register offset has no effect on the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 13 | Event pulses, one bit per source |
| reg_we_i | input | 1 | Register write strobe, taken on the clock edge |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 13 | Write data for the defined bits |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
Every result here is due one clock edge after its stimulus: an event or a register write presented before an edge shows in the state, readback and interrupt line immediately after that edge, since read data and the interrupt line are combinational from the registers. The bench drives all inputs on the falling edge and samples one falling edge later, so each check lands exactly one rising edge after the stimulus with no race at the active edge. Reads set the address on a falling edge and sample a short delay later, before the next rising edge can move any register.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;

  localparam int OFS_ENABLE = 'h10;
  localparam int OFS_MASK   = 'h14;
  localparam int OFS_CLEAR  = 'h18;
  localparam int OFS_STATE  = 'h1C;

  typedef enum int {
    SRC_FRAME_DONE   = 0,
    SRC_NODE_DONE    = 1,
    SRC_SCLR_DONE    = 2,
    SRC_SLICE_DONE   = 3,
    SRC_BUF_OVFL     = 4,
    SRC_BUF_SECTION  = 5,
    SRC_FRAME_ERR    = 6,
    SRC_WDOG         = 7,
    SRC_CHAIN_OPERR  = 8,
    SRC_CHAIN_ESTOP  = 9,
    SRC_CHAIN_PAUSE  = 10,
    SRC_CHAIN_NSTOP  = 11,
    SRC_CHAIN_DATERR = 12
  } irq_src_e;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] state_o
);
  // set dominates clear on a collision
  function automatic logic bit_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o[g] <= 1'b0;
      else        state_o[g] <= bit_next(state_o[g], set_i[g], clr_i[g]);
    end
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int N = 13
) (
  input  logic [N-1:0] state_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  function automatic logic visible_any(input logic [N-1:0] st, input logic [N-1:0] mk);
    return |(st & ~mk);
  endfunction

  assign irq_o = visible_any(state_i, mask_i);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC  = irq_ctrl_pkg::NUM_SRC,
  parameter int DW    = irq_ctrl_pkg::DATA_W,
  parameter int AW    = irq_ctrl_pkg::ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_EN  = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_MSK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_CLR = AW'(OFS_CLEAR);
  localparam logic [AW-1:0] A_ST  = AW'(OFS_STATE);

  logic            wr_en, wr_msk, wr_clr;
  logic [NSRC-1:0] en_q, mask_q, state_q;
  logic [NSRC-1:0] set_vec, clr_pulse;

  assign wr_en     = reg_we_i && (reg_addr_i == A_EN);
  assign wr_msk    = reg_we_i && (reg_addr_i == A_MSK);
  assign wr_clr    = reg_we_i && (reg_addr_i == A_CLR);
  assign clr_pulse = wr_clr ? reg_wdata_i : '0;
  assign set_vec   = evt_i & en_q;

  irq_cfg_reg #(.W(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wdata_i(reg_wdata_i), .q_o(en_q)
  );

  irq_cfg_reg #(.W(NSRC)) u_msk (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_msk), .wdata_i(reg_wdata_i), .q_o(mask_q)
  );

  irq_state_bank #(.N(NSRC)) u_state (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_pulse), .state_o(state_q)
  );

  irq_line_gen #(.N(NSRC)) u_line (
    .state_i(state_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_EN:    reg_rdata_o[NSRC-1:0] = en_q;
      A_MSK:   reg_rdata_o[NSRC-1:0] = mask_q;
      A_ST:    reg_rdata_o[NSRC-1:0] = state_q;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NSRC = 13,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] state_q,
  input logic [NSRC-1:0] clr_pulse,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_rdata_o,
  input logic            irq_o
);
  localparam logic [AW-1:0] A_CLR = AW'('h18);

  AST_ENABLED_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> ((state_q & $past(evt_i & en_q)) == $past(evt_i & en_q))); // R3

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((state_q & ~$past(state_q) & ~$past(en_q)) == '0)); // R4

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_pulse & ~(evt_i & en_q))) |=> ((state_q & $past(clr_pulse & ~(evt_i & en_q))) == '0)); // R5

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse == '0) |=> (($past(state_q) & ~state_q) == '0)); // R9

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_CLR) |-> (reg_rdata_o == '0)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[DW-1:NSRC] == '0); // R2

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0) |-> !irq_o); // R8
endmodule

bind irq_ctrl_unit irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_q(en_q), .mask_q(mask_q),
  .state_q(state_q), .clr_pulse(clr_pulse), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
);

// File: tb/irq_ctrl_unit_tb.sv
module irq_ctrl_unit_tb;
  localparam int N = 13;
  localparam logic [7:0] A_EN = 8'h10, A_MSK = 8'h14, A_CLR = 8'h18, A_ST = 8'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          reg_we_i = 1'b0;
  logic [7:0]    reg_addr_i = '0;
  logic [N-1:0]  reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  irq_ctrl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // bench-side expectation: line is up if any recorded bit is unhidden
  function automatic logic exp_line(input logic [N-1:0] st, input logic [N-1:0] mk);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) if (st[i] && !mk[i]) r = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_EN, d);  chk("R1 enable", d, 0);
    rd(A_MSK, d); chk("R1 mask", d, 0);
    rd(A_CLR, d); chk("R1 clear", d, 0);
    rd(A_ST, d);  chk("R1 state", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_rw();
    logic [31:0] d;
    wr(A_EN, 13'h1A5A); rd(A_EN, d); chk("R2 enable rb", d, 32'h1A5A);
    wr(A_MSK, 13'h05A5); rd(A_MSK, d); chk("R2 mask rb", d, 32'h05A5);
    wr(A_EN, 13'h1FFF); rd(A_EN, d); chk("R2 enable all, rsvd zero", d, 32'h1FFF);
    rd(8'h20, d); chk("R2 unmapped", d, 0);
    wr(A_MSK, '0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    wr(A_EN, 13'h1FFF);
    pulse(13'h0081);
    rd(A_ST, d); chk("R3 frame done + wdog set", d, 32'h0081);
    chk("R8 irq unmasked", {31'd0, irq_o}, {31'd0, exp_line(13'h0081, '0)});
    pulse(13'h1000);
    rd(A_ST, d); chk("R3 data error adds", d, 32'h1081);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_CLR, 13'h1FFF);
    wr(A_EN, 13'h0F0F);
    pulse(13'h1FFF);
    rd(A_ST, d); chk("R4 only enabled bits latch", d, 32'h0F0F);
    wr(A_CLR, 13'h1FFF);
    wr(A_EN, '0);
    pulse(13'h1FFF);
    rd(A_ST, d); chk("R4 all disabled", d, 0);
    chk("R4 irq low", {31'd0, irq_o}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_EN, 13'h1FFF);
    pulse(13'h00FF);
    wr(A_CLR, 13'h0033);
    rd(A_ST, d); chk("R5 partial clear", d, 32'h00CC);
    rd(A_CLR, d); chk("R7 clear reads zero", d, 0);
    wr(A_CLR, 13'h00CC);
    rd(A_ST, d); chk("R5 full clear", d, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(A_EN, 13'h1FFF);
    pulse(13'h0006);
    @(negedge clk);
    evt_i = 13'h0002; reg_we_i = 1'b1; reg_addr_i = A_CLR; reg_wdata_i = 13'h0006;
    @(negedge clk);
    evt_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
    rd(A_ST, d); chk("R6 event wins over clear", d, 32'h0002);
    wr(A_CLR, 13'h1FFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_EN, 13'h1FFF);
    pulse(13'h0410);
    wr(A_MSK, 13'h0410);
    rd(A_ST, d); chk("R8 mask keeps state", d, 32'h0410);
    chk("R8 masked irq low", {31'd0, irq_o}, {31'd0, exp_line(13'h0410, 13'h0410)});
    wr(A_MSK, 13'h0010);
    chk("R8 one bit unmasked", {31'd0, irq_o}, 1);
    wr(A_MSK, '0);
    wr(A_CLR, 13'h1FFF);
    chk("R8 irq low after clear", {31'd0, irq_o}, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(A_EN, 13'h1FFF);
    pulse(13'h0200);
    repeat (5) @(negedge clk);
    rd(A_ST, d); chk("R9 sticky", d, 32'h0200);
    wr(A_EN, '0);
    rd(A_ST, d); chk("R9 enable drop keeps bit", d, 32'h0200);
    wr(A_ST, '0);
    rd(A_ST, d); chk("R10 state write ignored", d, 32'h0200);
    wr(A_ST, 13'h1FFF);
    rd(A_ST, d); chk("R10 state write ones ignored", d, 32'h0200);
    wr(A_CLR, 13'h1FFF);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_latch();
    t_disabled();
    t_w1c();
    t_collision();
    t_mask();
    t_sticky();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule